// File: doc/BRIEF.md
# Coprocessor Conditional Branch Sequencer

This block runs in the execute stage of a host processor and carries out branches whose condition is judged by an attached coprocessor, not by the host. It takes a 16-bit opcode word and the address that word was fetched from. It checks the opcode and forwards the unchanged word to the chosen coprocessor's condition register over a one-cycle register-write bus. It then waits for a one-bit verdict from the coprocessor.

After the verdict arrives, the block pulls the remaining words of the instruction from an instruction-word stream. First come any extension words that the coprocessor defines, which are dropped unread. Then come the displacement words. The block ends with a one-cycle completion pulse, a branch-taken flag and the next program counter. That value is the branch target when the condition holds, and otherwise the address just past the instruction.

Top module: `cpbr_seq`

## Requirements
- R1: A word offered on `op_word` while `op_ready` is high is taken as a coprocessor branch only if bits 15:12 are 1111. Any other word is dropped: there is no write, no pulse, and `op_ready` stays high.
- R2: Bits 8:6 choose the displacement size: 010 is one 16-bit word, and 011 is 32 bits in two words. If an opcode has 1111 in bits 15:12 and any other size code, `unsup_o` pulses for one cycle in the cycle after acceptance, with no write.
- R3: In the cycle after a valid opcode is accepted, `wr_en` is high for exactly one cycle. In that cycle `wr_cpid` equals opcode bits 11:9 and `wr_data` equals the full 16-bit opcode word.
- R4: `rsp_valid` and `rsp_true` are sampled only in the waiting phase, which starts in the cycle after the write cycle. A response given during the write cycle is ignored.
- R5: If `rsp_valid` stays low for 64 consecutive waiting cycles, `err_o` pulses for one cycle in the next cycle, the block returns to idle and `done_o` does not pulse. A response in the 64th waiting cycle is still accepted.
- R6: The number of extension words for coprocessor id n is `ext_cfg[2n+1:2n]` (0 to 3). These words are taken from the stream before the displacement and are discarded. `iw_ready` is high only while stream words are being taken.
- R7: A 16-bit displacement is sign-extended. When the condition is true, `next_pc` is the address of the first displacement word (the opcode address + 2 + 2 × extension count) plus the displacement, modulo 2^32.
- R8: For size code 011, the first displacement word is bits 31:16 and the second is bits 15:0.
- R9: When the condition is false, `taken_o` is low and `next_pc` is the first displacement word address + 2 (16-bit form) or + 4 (32-bit form), modulo 2^32.
- R10: `done_o` pulses for one cycle in the cycle after the last displacement word is taken, and `op_ready` is high in that cycle. `op_ready` is high only when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode word offered |
| op_word | input | 16 | Opcode word |
| op_pc | input | 32 | Address of the opcode word |
| op_ready | output | 1 | Idle; opcode is taken when op_valid is high |
| ext_cfg | input | 16 | Two-bit extension-word count per coprocessor id |
| wr_en | output | 1 | Condition-register write strobe |
| wr_cpid | output | 3 | Coprocessor id of the write |
| wr_data | output | 16 | Data written (the opcode word) |
| rsp_valid | input | 1 | Coprocessor verdict valid |
| rsp_true | input | 1 | Condition true |
| iw_valid | input | 1 | Instruction-stream word valid |
| iw_data | input | 16 | Instruction-stream word |
| iw_ready | output | 1 | Stream word is taken when iw_valid is high |
| done_o | output | 1 | Branch resolved (one-cycle pulse) |
| taken_o | output | 1 | Condition was true (valid with done_o) |
| next_pc | output | 32 | Next program counter (valid with done_o) |
| err_o | output | 1 | Response timeout (one-cycle pulse) |
| unsup_o | output | 1 | Unsupported size code (one-cycle pulse) |

## Verification
A wrong sequencer state shows up at once on the handshake pins. A missing or extra write cycle is visible one cycle after acceptance. A miscounted extension word shifts which stream word is taken as the displacement, so `next_pc` is off by at least a word when `done_o` fires. A timeout counter that is off by one moves the `err_o` pulse by one cycle, and the 64th-cycle response vector turns that into a lost branch. Signed wrap-around of the target is exercised with negative displacements near both ends of the address space.

// File: rtl/cpbr_pkg.sv
package cpbr_pkg;

    localparam int WORD_W   = 16;
    localparam int CPID_W   = 3;
    localparam int N_CP     = 1 << CPID_W;
    localparam int EXT_W    = 2;
    localparam int CFG_W    = N_CP * EXT_W;

    localparam logic [3:0] LINE_F  = 4'hF;
    localparam logic [2:0] SZ_WORD = 3'b010;
    localparam logic [2:0] SZ_LONG = 3'b011;

    typedef struct packed {
        logic             fline;
        logic             size_ok;
        logic             is_long;
        logic [EXT_W-1:0] ext_n;
    } op_dec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_WAIT,
        ST_EXT,
        ST_DISP0,
        ST_DISP1
    } seq_st_t;

    function automatic logic [31:0] sext16(input logic [15:0] w);
        return {{16{w[15]}}, w};
    endfunction

endpackage

// File: rtl/cpbr_decode.sv
module cpbr_decode
    import cpbr_pkg::*;
(
    input  logic [WORD_W-1:6] hdr,
    input  logic [CFG_W-1:0]  ext_cfg,
    output op_dec_t           dec
);
    logic [EXT_W-1:0] ext_tab [N_CP];

    for (genvar g = 0; g < N_CP; g++) begin : g_ext
        assign ext_tab[g] = ext_cfg[g*EXT_W +: EXT_W];
    end

    logic [2:0] size_code;
    logic [CPID_W-1:0] cpid;

    always_comb begin
        size_code   = hdr[8:6];
        cpid        = hdr[11:9];
        dec.fline   = (hdr[15:12] == LINE_F);
        dec.size_ok = (size_code == SZ_WORD) || (size_code == SZ_LONG);
        dec.is_long = (size_code == SZ_LONG);
        dec.ext_n   = ext_tab[cpid];
    end
endmodule

// File: rtl/cpbr_wait_timer.sv
module cpbr_wait_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/cpbr_target.sv
module cpbr_target
    import cpbr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] disp_addr,
    input  logic              is_long,
    input  logic              cond,
    input  logic [WORD_W-1:0] disp_hi,
    input  logic [WORD_W-1:0] disp_last,
    output logic [ADDR_W-1:0] npc
);
    logic [31:0]       disp32;
    logic [ADDR_W-1:0] fall;

    always_comb begin
        disp32 = is_long ? {disp_hi, disp_last} : sext16(disp_last);
        fall   = disp_addr + (is_long ? ADDR_W'(4) : ADDR_W'(2));
        npc    = cond ? (disp_addr + ADDR_W'(disp32)) : fall;
    end
endmodule

// File: rtl/cpbr_seq.sv
module cpbr_seq
    import cpbr_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [WORD_W-1:0]   op_word,
    input  logic [ADDR_W-1:0]   op_pc,
    output logic                op_ready,
    input  logic [CFG_W-1:0]    ext_cfg,
    output logic                wr_en,
    output logic [CPID_W-1:0]   wr_cpid,
    output logic [WORD_W-1:0]   wr_data,
    input  logic                rsp_valid,
    input  logic                rsp_true,
    input  logic                iw_valid,
    input  logic [WORD_W-1:0]   iw_data,
    output logic                iw_ready,
    output logic                done_o,
    output logic                taken_o,
    output logic [ADDR_W-1:0]   next_pc,
    output logic                err_o,
    output logic                unsup_o
);
    seq_st_t           st;
    op_dec_t           dec;
    logic [WORD_W-1:0] op_q;
    logic              long_q;
    logic              cond_q;
    logic [EXT_W-1:0]  ext_left;
    logic [ADDR_W-1:0] daddr_q;
    logic [WORD_W-1:0] hi_q;
    logic [ADDR_W-1:0] npc_w;
    logic              expired;
    logic              accept;
    logic              iw_fire;
    logic              last_word;

    cpbr_decode u_dec (
        .hdr     (op_word[WORD_W-1:6]),
        .ext_cfg (ext_cfg),
        .dec     (dec)
    );

    cpbr_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (st == ST_WAIT),
        .expired (expired)
    );

    cpbr_target #(.ADDR_W(ADDR_W)) u_tgt (
        .disp_addr (daddr_q),
        .is_long   (long_q),
        .cond      (cond_q),
        .disp_hi   (hi_q),
        .disp_last (iw_data),
        .npc       (npc_w)
    );

    assign op_ready  = (st == ST_IDLE);
    assign accept    = op_valid && op_ready;
    assign wr_en     = (st == ST_WRITE);
    assign wr_cpid   = op_q[11:9];
    assign wr_data   = op_q;
    assign iw_ready  = (st == ST_EXT) || (st == ST_DISP0) || (st == ST_DISP1);
    assign iw_fire   = iw_valid && iw_ready;
    assign last_word = iw_fire && (((st == ST_DISP0) && !long_q) || (st == ST_DISP1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            op_q     <= '0;
            long_q   <= 1'b0;
            cond_q   <= 1'b0;
            ext_left <= '0;
            daddr_q  <= '0;
            hi_q     <= '0;
            done_o   <= 1'b0;
            taken_o  <= 1'b0;
            next_pc  <= '0;
            err_o    <= 1'b0;
            unsup_o  <= 1'b0;
        end else begin
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            unsup_o <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (accept && dec.fline) begin
                        if (dec.size_ok) begin
                            op_q     <= op_word;
                            long_q   <= dec.is_long;
                            ext_left <= dec.ext_n;
                            daddr_q  <= op_pc + ADDR_W'(2)
                                        + ADDR_W'({dec.ext_n, 1'b0});
                            st       <= ST_WRITE;
                        end else begin
                            unsup_o <= 1'b1;
                        end
                    end
                end
                ST_WRITE: st <= ST_WAIT;
                ST_WAIT: begin
                    if (rsp_valid) begin
                        cond_q <= rsp_true;
                        st     <= (ext_left != '0) ? ST_EXT : ST_DISP0;
                    end else if (expired) begin
                        err_o <= 1'b1;
                        st    <= ST_IDLE;
                    end
                end
                ST_EXT: begin
                    if (iw_fire) begin
                        ext_left <= ext_left - 1'b1;
                        if (ext_left == EXT_W'(1)) st <= ST_DISP0;
                    end
                end
                ST_DISP0: begin
                    if (iw_fire && long_q) begin
                        hi_q <= iw_data;
                        st   <= ST_DISP1;
                    end
                end
                ST_DISP1: ;
                default: st <= ST_IDLE;
            endcase
            if (last_word) begin
                done_o  <= 1'b1;
                taken_o <= cond_q;
                next_pc <= npc_w;
                st      <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/cpbr_seq_chk.sv
module cpbr_seq_chk
    import cpbr_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [WORD_W-1:0] op_word,
    input logic              op_ready,
    input logic              wr_en,
    input logic [CPID_W-1:0] wr_cpid,
    input logic [WORD_W-1:0] wr_data,
    input logic              iw_ready,
    input logic              done_o,
    input logic              err_o,
    input logic              unsup_o
);
    logic        waiting;
    logic [15:0] wcnt;
    logic        acc_f, size_ok;

    assign waiting = !op_ready && !iw_ready && !wr_en;
    assign acc_f   = op_valid && op_ready && (op_word[15:12] == 4'hF);
    assign size_ok = (op_word[8:6] == 3'b010) || (op_word[8:6] == 3'b011);

    always_ff @(posedge clk) begin
        if (rst || !waiting) wcnt <= '0;
        else if (wcnt != 16'hFFFF) wcnt <= wcnt + 1'b1;
    end

    assert_nonf_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_word[15:12] != 4'hF) |=> (!wr_en && !unsup_o && op_ready));

    assert_bad_size_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_f && !size_ok) |=> (unsup_o && !wr_en && op_ready));

    assert_write_word_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_f && size_ok) |=> (wr_en && wr_data == $past(op_word)
                                && wr_cpid == $past(op_word[11:9])));

    assert_write_once_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    assert_wait_after_write_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (!iw_ready && !op_ready));

    assert_timeout_len_R5: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (wcnt == 16'(TIMEOUT_CYC)));

    assert_wait_bound_R5: assert property (@(posedge clk) disable iff (rst)
        wcnt <= 16'(TIMEOUT_CYC));

    assert_stream_busy_R6: assert property (@(posedge clk) disable iff (rst)
        iw_ready |-> (!op_ready && !wr_en));

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (op_ready && !iw_ready));

    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_o, err_o, unsup_o}));
endmodule

bind cpbr_seq cpbr_seq_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_word  (op_word),
    .op_ready (op_ready),
    .wr_en    (wr_en),
    .wr_cpid  (wr_cpid),
    .wr_data  (wr_data),
    .iw_ready (iw_ready),
    .done_o   (done_o),
    .err_o    (err_o),
    .unsup_o  (unsup_o)
);

// File: tb/cpbr_seq_tb.sv
module cpbr_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] CFG = 16'hE4E4; // id n -> n mod 4 extension words

    typedef struct packed {
        logic [15:0] op;
        logic [31:0] pc;
        logic        cond;
        logic [31:0] disp;
        logic [7:0]  dly;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{16'hF085, 32'h0000_1000, 1'b1, 32'h0000_0010, 8'd0},
        '{16'hF28A, 32'h0000_2000, 1'b1, 32'h0000_FFF0, 8'd1},
        '{16'hF4FF, 32'h0000_3000, 1'b1, 32'h0001_2345, 8'd5},
        '{16'hF6C1, 32'h0000_4000, 1'b0, 32'h8000_0000, 8'd2},
        '{16'hF892, 32'h0000_5000, 1'b0, 32'h0000_7FFF, 8'd63},
        '{16'hFEE0, 32'hFFFF_FFF0, 1'b1, 32'hFFFF_FFFE, 8'd1},
        '{16'hFA80, 32'hFFFF_FFFC, 1'b1, 32'h0000_8000, 8'd0},
        '{16'hFCC7, 32'h0000_7000, 1'b0, 32'h0000_0100, 8'd63}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [15:0] op_word = '0;
    logic [31:0] op_pc = '0;
    logic        op_ready;
    logic        wr_en;
    logic [2:0]  wr_cpid;
    logic [15:0] wr_data;
    logic        rsp_valid = 1'b0;
    logic        rsp_true = 1'b0;
    logic        iw_valid = 1'b0;
    logic [15:0] iw_data = '0;
    logic        iw_ready;
    logic        done_o, taken_o, err_o, unsup_o;
    logic [31:0] next_pc;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpbr_seq dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_word(op_word), .op_pc(op_pc),
        .op_ready(op_ready), .ext_cfg(CFG), .wr_en(wr_en), .wr_cpid(wr_cpid),
        .wr_data(wr_data), .rsp_valid(rsp_valid), .rsp_true(rsp_true),
        .iw_valid(iw_valid), .iw_data(iw_data), .iw_ready(iw_ready),
        .done_o(done_o), .taken_o(taken_o), .next_pc(next_pc),
        .err_o(err_o), .unsup_o(unsup_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_branch(input logic [15:0] op, input logic [31:0] pc,
                              input logic cond, input logic [31:0] disp, input int dly);
        logic [2:0]  id;
        int          ext, n;
        logic        lng;
        logic [31:0] daddr, d32, exp_pc;
        id    = op[11:9];
        ext   = int'(CFG[id*2 +: 2]);
        lng   = (op[8:6] == 3'b011);
        n     = ext + (lng ? 2 : 1);
        daddr = pc + 32'd2 + 32'(2 * ext);
        d32   = lng ? disp : {{16{disp[15]}}, disp[15:0]};
        exp_pc = cond ? daddr + d32 : daddr + (lng ? 32'd4 : 32'd2);
        @(negedge clk);
        chk("R10 idle ready", 32'(op_ready), 32'd1);
        op_valid = 1'b1; op_word = op; op_pc = pc;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R3 wr_en", 32'(wr_en), 32'd1);
        chk("R3 wr_cpid", 32'(wr_cpid), 32'(id));
        chk("R3 wr_data", 32'(wr_data), 32'(op));
        chk("R10 busy", 32'(op_ready), 32'd0);
        @(negedge clk);
        chk("R3 single write", 32'(wr_en), 32'd0);
        repeat (dly) @(negedge clk);
        chk("R4 waiting no stream", 32'(iw_ready), 32'd0);
        rsp_valid = 1'b1; rsp_true = cond;
        @(negedge clk);
        rsp_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            iw_valid = 1'b1;
            if (k < ext)            iw_data = 16'hE0A0 + 16'(k);
            else if (lng && k == ext) iw_data = disp[31:16];
            else                    iw_data = disp[15:0];
            chk("R6 stream ready", 32'(iw_ready), 32'd1);
            @(negedge clk);
        end
        iw_valid = 1'b0;
        chk("R10 done", 32'(done_o), 32'd1);
        chk(cond ? "R7 taken" : "R9 not taken", 32'(taken_o), 32'(cond));
        chk(lng ? (cond ? "R8 long target" : "R9 long fall") :
                  (cond ? "R7 word target" : "R9 word fall"), next_pc, exp_pc);
        chk("R6 stream closed", 32'(iw_ready), 32'd0);
        chk("R10 ready at done", 32'(op_ready), 32'd1);
        @(negedge clk);
        chk("R10 done pulse", 32'(done_o), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R10 reset ready", 32'(op_ready), 32'd1);
        chk("R3 reset wr_en", 32'(wr_en), 32'd0);
        chk("R6 reset iw_ready", 32'(iw_ready), 32'd0);
        chk("R10 reset done", 32'(done_o), 32'd0);

        foreach (VECS[i])
            run_branch(VECS[i].op, VECS[i].pc, VECS[i].cond, VECS[i].disp, int'(VECS[i].dly));

        // R1: non-F-line word dropped
        @(negedge clk);
        op_valid = 1'b1; op_word = 16'h7085;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R1 no write", 32'(wr_en), 32'd0);
        chk("R1 no unsup", 32'(unsup_o), 32'd0);
        chk("R1 still ready", 32'(op_ready), 32'd1);

        // R2: bad size codes
        for (int s = 0; s < 2; s++) begin
            @(negedge clk);
            op_valid = 1'b1; op_word = (s == 0) ? 16'hF1C0 : 16'hF040;
            @(negedge clk);
            op_valid = 1'b0;
            chk("R2 unsup pulse", 32'(unsup_o), 32'd1);
            chk("R2 no write", 32'(wr_en), 32'd0);
            @(negedge clk);
            chk("R2 unsup one cycle", 32'(unsup_o), 32'd0);
            chk("R2 no late write", 32'(wr_en), 32'd0);
        end

        // R4 + R5: response during write ignored, then timeout
        @(negedge clk);
        op_valid = 1'b1; op_word = 16'hF085; op_pc = 32'h0;
        @(negedge clk);
        op_valid = 1'b0;
        rsp_valid = 1'b1; rsp_true = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk("R4 write-cycle rsp ignored", 32'(iw_ready), 32'd0);
        repeat (63) @(negedge clk);
        chk("R5 no early err", 32'(err_o), 32'd0);
        chk("R5 still waiting", 32'(op_ready), 32'd0);
        @(negedge clk);
        chk("R5 err pulse", 32'(err_o), 32'd1);
        chk("R5 back idle", 32'(op_ready), 32'd1);
        chk("R5 no done", 32'(done_o), 32'd0);
        @(negedge clk);
        chk("R5 err one cycle", 32'(err_o), 32'd0);

        run_branch(16'hF2C3, 32'h0000_9000, 1'b1, 32'hFFFF_0000, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule